// File: doc/BRIEF.md
# Flash status register and STS pin controller

This block is the status-reporting part of a NOR-flash-style command interface. It holds an 8-bit status word. Some bits track the write state machine live: ready, erase suspended and program suspended. Others are sticky error flags. These are set by error events and stay set until software issues the clear-status command (50h) or the device is reset.

The block also drives the STS output pin. After reset the pin is a ready/busy level. A two-write configuration sequence changes this. The sequence is command B8h followed by a code byte. The code can make the pin idle high and drop low for a fixed number of clocks when an erase completes, when a program completes, or on both. The configuration is accepted only while the state machine is neither busy nor suspended. A code outside 00h..03h flags a command error in the status word.

Top module: `flash_stat_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the sticky bits (status bits 5, 4, 3, 1) read 0 and the STS pin is in level mode. This also holds after a reset in the middle of a run.
- R2: Status bit 7 reads the inverse of `wsm_busy`, bit 6 reads `erase_susp`, bit 2 reads `prog_susp` and bit 0 reads 0, in the same cycle as the inputs.
- R3: A one-cycle pulse on `err_evt[3]`, `[2]`, `[1]` or `[0]` sets status bit 5, 4, 3 or 1 respectively from the next cycle on. The bit stays set while no clear occurs.
- R4: A write of 50h, when no configuration code is pending, clears all sticky bits from the next cycle. An error event in the same cycle still sets its bit.
- R5: In level mode `sts_o` equals the inverse of `wsm_busy`, in the same cycle, so it is high while suspended.
- R6: A write of B8h while idle, followed by a write of a code from 00h to 03h, sets the STS mode to code bits [1:0] from the cycle after the code write. The mode holds until the next accepted configuration.
- R7: A B8h write while `wsm_busy`, `erase_susp` or `prog_susp` is high is ignored. The following write is then decoded as an ordinary command and does not change the mode.
- R8: A code byte above 03h after B8h sets status bits 5 and 4 from the next cycle and leaves the mode unchanged.
- R9: With mode bit 0 set, an `op_done` pulse with `op_kind` = 01 (erase) drives `sts_o` low for PULSE_LEN cycles starting the cycle after the event. Otherwise `sts_o` is high in pulse modes.
- R10: With mode bit 1 set, an `op_done` pulse with `op_kind` = 00 (program) gives the same low pulse. A kind whose mode bit is clear gives no pulse.
- R11: `op_done` with `op_kind` = 10 (set lock) or 11 (clear lock) never gives a pulse, in any mode.
- R12: Configuration code 00h returns the STS pin to level mode. A new enabled completion during a pulse restarts the PULSE_LEN count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| cmd_we | input | 1 | Command byte write strobe, one cycle per byte |
| cmd_data | input | 8 | Command or configuration code byte |
| wsm_busy | input | 1 | Write state machine is running an operation |
| erase_susp | input | 1 | An erase is suspended |
| prog_susp | input | 1 | A program is suspended |
| op_done | input | 1 | One-cycle pulse at the end of an operation |
| op_kind | input | 2 | Kind of finished operation: 00 program, 01 erase, 10 set lock, 11 clear lock |
| err_evt | input | 4 | One-cycle error events for status bits 5, 4, 3, 1 (msb first) |
| status | output | 8 | Status word |
| sts_o | output | 1 | STS pin: ready/busy level or completion pulses |

## Verification
The assertions take `op_done` and `err_evt` as single-cycle, synchronous strobes. They also assume the state machine lowers `wsm_busy` while it reports a suspend. This is why a level-mode STS pin reads high during suspend. The stimulus keeps within these limits: inputs change shortly after the rising edge, completion events last exactly one vector, and busy and suspend flags are never both high. Configuration attempts are made both in the idle state and against each blocking flag. The pin is checked cycle by cycle against a bench model of the pulse counter.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_STS_CFG  = 8'hB8;
  localparam logic [7:0] CODE_MAX     = 8'h03;

  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_ERASE  = 2'b01,
    OP_LKSET  = 2'b10,
    OP_LKCLR  = 2'b11
  } op_kind_e;

  function automatic logic code_ok(input logic [7:0] code);
    return code <= CODE_MAX;
  endfunction

  function automatic logic pulse_en(input logic [1:0] mode, input logic [1:0] kind);
    return ((kind == OP_ERASE) && mode[0]) || ((kind == OP_PROG) && mode[1]);
  endfunction

  function automatic logic [7:0] pack_status(input logic busy, input logic esus,
                                             input logic psus, input logic [3:0] stk);
    return {~busy, esus, stk[3], stk[2], stk[1], psus, stk[0], 1'b0};
  endfunction
endpackage

// File: rtl/fsc_cmd_dec.sv
module fsc_cmd_dec
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       busy,
  input  logic       susp,
  output logic       clr_evt,
  output logic       cfg_load,
  output logic [1:0] cfg_code,
  output logic       code_bad
);
  logic armed;
  logic code_write;
  logic arm_req;
  logic idle;

  assign idle       = !busy && !susp;
  assign code_write = cmd_we && armed;
  assign cfg_load   = code_write && code_ok(cmd_data);
  assign code_bad   = code_write && !code_ok(cmd_data);
  assign cfg_code   = cmd_data[1:0];
  assign clr_evt    = cmd_we && !armed && (cmd_data == CMD_CLR_STAT);
  assign arm_req    = cmd_we && !armed && (cmd_data == CMD_STS_CFG) && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (code_write) armed <= 1'b0;
    else if (arm_req)    armed <= 1'b1;
  end

  // R7: a configuration command seen while not idle must leave nothing pending
  p_no_arm_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !armed && cmd_data == CMD_STS_CFG && !idle) |=> !armed);

  // R6: the code byte always consumes the pending state
  p_code_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load || code_bad) |=> !armed);
endmodule

// File: rtl/fsc_stat_reg.sv
module fsc_stat_reg
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_evt,
  input  logic       code_bad,
  input  logic [3:0] err_evt,
  input  logic       busy,
  input  logic       esus,
  input  logic       psus,
  output logic [3:0] sticky,
  output logic [7:0] status
);
  logic [3:0] set_vec;

  assign set_vec = err_evt | (code_bad ? 4'b1100 : 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (clr_evt ? 4'b0000 : sticky) | set_vec;
  end

  assign status = pack_status(busy, esus, psus, sticky);

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |=> ((sticky & $past(sticky)) == $past(sticky)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && err_evt == 4'b0000 && !code_bad) |=> (status[5:3] == 3'b000 && !status[1]));

  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_bad |=> (status[5:4] == 2'b11));

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n) !status[0]);
endmodule

// File: rtl/fsc_sts_drv.sv
module fsc_sts_drv
  import fsc_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic [1:0] cfg_code,
  input  logic       op_done,
  input  logic [1:0] op_kind,
  input  logic       busy,
  output logic       sts_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt;
  logic             fire;
  logic             pulse_low;

  assign fire      = op_done && pulse_en(mode, op_kind);
  assign pulse_low = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode <= 2'b00;
    else if (cfg_load) mode <= cfg_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (cfg_load)  cnt <= '0;
    else if (fire)      cnt <= CNT_W'(PULSE_LEN);
    else if (pulse_low) cnt <= cnt - 1'b1;
  end

  assign sts_o = (mode == 2'b00) ? ~busy : ~pulse_low;

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(mode));

  p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_load) |=> !sts_o);

  p_quiet_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && !cfg_load && !fire && !pulse_low) |=> sts_o);

  p_lock_no_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_kind[1]) |-> !fire);
endmodule

// File: rtl/flash_stat_ctl.sv
module flash_stat_ctl
  import fsc_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       wsm_busy,
  input  logic       erase_susp,
  input  logic       prog_susp,
  input  logic       op_done,
  input  logic [1:0] op_kind,
  input  logic [3:0] err_evt,
  output logic [7:0] status,
  output logic       sts_o
);
  logic       clr_evt;
  logic       cfg_load;
  logic [1:0] cfg_code;
  logic       code_bad;
  logic [3:0] sticky;

  fsc_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .busy(wsm_busy), .susp(erase_susp | prog_susp),
    .clr_evt(clr_evt), .cfg_load(cfg_load), .cfg_code(cfg_code), .code_bad(code_bad)
  );

  fsc_stat_reg u_sr (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .code_bad(code_bad),
    .err_evt(err_evt), .busy(wsm_busy), .esus(erase_susp), .psus(prog_susp),
    .sticky(sticky), .status(status)
  );

  fsc_sts_drv #(.PULSE_LEN(PULSE_LEN)) u_sts (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
    .op_done(op_done), .op_kind(op_kind), .busy(wsm_busy), .sts_o(sts_o)
  );

  p_reset_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sticky == 4'b0000));
endmodule

// File: tb/flash_stat_ctl_tb_top.sv
`timescale 1ns/100ps
module flash_stat_ctl_tb_top;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       wsm_busy = 1'b0;
  logic       erase_susp = 1'b0;
  logic       prog_susp = 1'b0;
  logic       op_done = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [3:0] err_evt = 4'b0000;
  logic [7:0] status;
  logic       sts_o;

  always #2.5 clk = ~clk;

  flash_stat_ctl #(.PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .wsm_busy(wsm_busy), .erase_susp(erase_susp), .prog_susp(prog_susp),
    .op_done(op_done), .op_kind(op_kind), .err_evt(err_evt),
    .status(status), .sts_o(sts_o)
  );

  // bench model of the requirements
  logic [3:0] m_stk;   // {bit5, bit4, bit3, bit1}
  logic [1:0] m_mode;
  logic       m_arm;
  int         m_cnt;

  logic [7:0] q_st[$];
  logic       q_sts[$];
  string      q_req[$];
  int         n_vec = 0;
  int         n_bad = 0;
  bit         finished = 0;

  task automatic model_reset();
    m_stk = 4'b0; m_mode = 2'b00; m_arm = 1'b0; m_cnt = 0;
  endtask

  task automatic vec(input bit we, input logic [7:0] d, input bit b, input bit es,
                     input bit ps, input bit dn, input logic [1:0] k,
                     input logic [3:0] e, input string req);
    logic [7:0] est;
    logic       ests;
    bit         clr, inv, load, fire;
    @(posedge clk); #1;
    cmd_we = we; cmd_data = d; wsm_busy = b; erase_susp = es; prog_susp = ps;
    op_done = dn; op_kind = k; err_evt = e;
    est  = {~b, es, m_stk[3], m_stk[2], m_stk[1], ps, m_stk[0], 1'b0};
    ests = (m_mode == 2'b00) ? ~b : (m_cnt == 0);
    q_st.push_back(est); q_sts.push_back(ests); q_req.push_back(req);
    clr = 0; inv = 0; load = 0;
    if (we && m_arm) begin
      if (d <= 8'h03) load = 1; else inv = 1;
    end else if (we && d == 8'h50) clr = 1;
    fire = dn && (((k == 2'b01) && m_mode[0]) || ((k == 2'b00) && m_mode[1]));
    m_stk = (clr ? 4'b0 : m_stk) | e | (inv ? 4'b1100 : 4'b0);
    if (load) m_cnt = 0;
    else if (fire) m_cnt = PL;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (we && m_arm) m_arm = 0;
    else if (we && d == 8'hB8 && !b && !es && !ps) m_arm = 1;
    if (load) m_mode = d[1:0];
  endtask

  task automatic idle(input int n, input bit b, input string req);
    for (int i = 0; i < n; i++) vec(0, 8'h00, b, 0, 0, 0, 2'b00, 4'b0, req);
  endtask

  task automatic cfg(input logic [7:0] code, input string req);
    vec(1, 8'hB8, 0, 0, 0, 0, 2'b00, 4'b0, req);
    vec(1, code, 0, 0, 0, 0, 2'b00, 4'b0, req);
  endtask

  task automatic done(input logic [1:0] k, input string req);
    vec(0, 8'h00, 0, 0, 0, 1, k, 4'b0, req);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; cmd_we = 0; op_done = 0; err_evt = 0;
    wsm_busy = 0; erase_susp = 0; prog_susp = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // monitor: compare design outputs with queued expectations
  always @(negedge clk) begin
    if (q_st.size() != 0) begin
      logic [7:0] est;
      logic       ests;
      string      r;
      est = q_st.pop_front(); ests = q_sts.pop_front(); r = q_req.pop_front();
      n_vec++;
      if (status !== est || sts_o !== ests) begin
        n_bad++;
        $display("FAIL %s: status=%02h sts=%b expected status=%02h sts=%b",
                 r, status, sts_o, est, ests);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state, R2 live bits, R5 level pin
    idle(2, 0, "R1");
    idle(2, 1, "R5");
    vec(0, 8'h00, 0, 1, 0, 0, 2'b00, 4'b0, "R2");
    vec(0, 8'h00, 0, 0, 1, 0, 2'b00, 4'b0, "R2");
    vec(0, 8'h00, 0, 1, 1, 0, 2'b00, 4'b0, "R5");
    // R3 sticky bits
    vec(0, 8'h00, 1, 0, 0, 0, 2'b00, 4'b0001, "R3");
    vec(0, 8'h00, 1, 0, 0, 0, 2'b00, 4'b0100, "R3");
    idle(3, 0, "R3");
    vec(0, 8'h00, 0, 0, 0, 0, 2'b00, 4'b1010, "R3");
    idle(2, 0, "R3");
    // R4 clear, plus set in same cycle
    vec(1, 8'h50, 0, 0, 0, 0, 2'b00, 4'b0, "R4");
    idle(2, 0, "R4");
    vec(0, 8'h00, 0, 0, 0, 0, 2'b00, 4'b1111, "R4");
    vec(1, 8'h50, 0, 0, 0, 0, 2'b00, 4'b0010, "R4");
    idle(2, 0, "R4");
    vec(1, 8'h50, 1, 0, 0, 0, 2'b00, 4'b0, "R4");
    idle(1, 0, "R4");
    // R7 config blocked by busy and each suspend
    vec(1, 8'hB8, 1, 0, 0, 0, 2'b00, 4'b0, "R7");
    vec(1, 8'h02, 0, 0, 0, 0, 2'b00, 4'b0, "R7");
    vec(1, 8'hB8, 0, 1, 0, 0, 2'b00, 4'b0, "R7");
    vec(1, 8'h03, 0, 0, 0, 0, 2'b00, 4'b0, "R7");
    vec(1, 8'hB8, 0, 0, 1, 0, 2'b00, 4'b0, "R7");
    vec(1, 8'h50, 0, 0, 0, 0, 2'b00, 4'b0001, "R7");
    done(2'b00, "R7");
    idle(2, 1, "R7");
    idle(2, 0, "R7");
    // R10 program pulse, erase ignored
    cfg(8'h02, "R6");
    idle(2, 1, "R6");
    done(2'b00, "R10");
    idle(PL + 2, 0, "R10");
    done(2'b01, "R10");
    idle(2, 0, "R10");
    // R9 erase pulse, program ignored
    cfg(8'h01, "R6");
    done(2'b01, "R9");
    idle(PL + 2, 0, "R9");
    done(2'b00, "R9");
    idle(2, 0, "R9");
    // both, R11 lock operations
    cfg(8'h03, "R6");
    done(2'b10, "R11");
    done(2'b11, "R11");
    idle(2, 0, "R11");
    done(2'b00, "R10");
    idle(PL + 1, 0, "R10");
    // R12 retrigger during a pulse
    done(2'b01, "R12");
    idle(2, 0, "R12");
    done(2'b00, "R12");
    idle(PL + 2, 0, "R12");
    // R8 invalid code: error bits, mode unchanged
    cfg(8'h07, "R8");
    idle(2, 0, "R8");
    done(2'b01, "R8");
    idle(PL + 1, 0, "R8");
    cfg(8'hB8, "R8");
    idle(1, 0, "R8");
    vec(1, 8'h50, 0, 0, 0, 0, 2'b00, 4'b0, "R4");
    // R12 back to level
    cfg(8'h00, "R12");
    idle(2, 1, "R12");
    done(2'b01, "R12");
    idle(2, 0, "R12");
    // R1 mid-run reset
    cfg(8'h03, "R6");
    vec(0, 8'h00, 0, 0, 0, 0, 2'b00, 4'b1111, "R3");
    done(2'b01, "R9");
    do_reset();
    idle(2, 1, "R1");
    idle(2, 0, "R1");
    done(2'b01, "R1");
    idle(2, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    if (q_st.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d expectations left, expected 0", q_st.size());
    end
    finish_run();
  end
endmodule